// File: doc/BRIEF.md
# Dash Stopwatch with Best-Time Memory

This block times sprint runs on a 100 Hz clock and remembers the fastest run of the current session. A four-digit packed-BCD timer counts hundredths of a second while a run is in progress. When the runner asks for a comparison, the timer is checked against a stored best time. The timer replaces the best time only when it is strictly smaller. The chosen value is shown on four seven-segment digit vectors with a fixed decimal point, in the form 00.00 to 99.99.

A seven-state one-hot Moore controller sequences the datapath. The states are: initialise, idle, running, halted, compare, store and show-best. The controller drives the datapath through a small bundle of strobes. These are: load best, clear timer, count, best-source select and display select. The datapath returns a single less-than status. A session ends with the asynchronous clear, which brings the best time back to 99.99. Button conditioning and the physical display driver sit outside the block.

Top module: `dash_timer_top`

## Requirements
- R1: While `clearAll` is high, the controller is held in its initial state and the timer reads 0000, so the display shows 00.00.
- R2: After clear is released, one clock passes through the initial state. That state loads 99.99 into the best register. The controller then waits idle. A `startBtn` pulse in idle clears the timer and begins a run from zero.
- R3: During a run, the timer adds one in BCD on every clock, with carries between digits. The clock on which `stopBtn` is seen also counts. After the stop, the display shows the elapsed count.
- R4: The timer saturates at 99.99 and holds that value instead of wrapping.
- R5: `cssBtn` in the halted state starts a comparison. If the timer is strictly smaller than the best time, the best time takes the timer value. Two clocks later the display shows the best time.
- R6: A timer value equal to or greater than the best time leaves the best time unchanged.
- R7: `startBtn` in the halted or show-best state returns to idle. Idle clears the timer, so the display reads 00.00 while waiting.
- R8: In the halted state, `cssBtn` has priority over `startBtn` when both are high.
- R9: A clear in the middle of a session restores the best time to 99.99.
- R10: `segOut` is laid out as follows, from MSB to LSB:
  - tens digit [28:22]
  - units digit [21:15]
  - decimal point [14], always 1
  - tenths digit [13:7]
  - hundredths digit [6:0]

  Each digit is active-high, with segments a..g from MSB to LSB. The codes are 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B (hex).
- R11: Outside the run and idle-clear states, the timer holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 Hz clock |
| clearAll | input | 1 | Asynchronous session clear, active high |
| startBtn | input | 1 | Start a run, or leave a result view |
| stopBtn | input | 1 | End the current run |
| cssBtn | input | 1 | Compare the run with the best time and keep the smaller |
| segOut | output | 29 | Four seven-segment digit vectors plus the decimal point |

## Verification
The checker asserts on every cycle that exactly one state bit is set. It also checks these datapath rules:
- the timer changes only when counting or clearing;
- the timer never leaves 99.99 once it has saturated;
- the best register changes only on a load strobe;
- the store state is reached only with the timer strictly below the best time;
- the decimal point stays lit.

Only the directed scenarios can show the behaviour at the segment outputs. These are:
- BCD carry values;
- how a tie is handled;
- `cssBtn` taking priority over `startBtn`;
- the best time returning to 99.99 after a mid-session clear.

// File: rtl/swatch_pkg.sv
package swatch_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;
  localparam int NUM_ST  = 7;

  // one-hot state bit positions
  localparam int ST_INIT  = 0;
  localparam int ST_IDLE  = 1;
  localparam int ST_RUN   = 2;
  localparam int ST_HALT  = 3;
  localparam int ST_CMP   = 4;
  localparam int ST_STORE = 5;
  localparam int ST_BEST  = 6;

  typedef struct packed {
    logic ldBest;    // load the best-time register
    logic clrTimer;  // synchronous timer clear
    logic cntEn;     // timer count enable
    logic srcTimer;  // best source: 1 = timer, 0 = all nines
    logic showBest;  // display source: 1 = best, 0 = timer
  } swCtrl_t;
endpackage

// File: rtl/swatch_seg7.sv
module swatch_seg7
  import swatch_pkg::*;
(
  input  logic [DIGIT_W-1:0] bcd,
  output logic [SEG_W-1:0]   seg
);
  always_comb begin
    case (bcd)
      4'd0:    seg = 7'b1111110;
      4'd1:    seg = 7'b0110000;
      4'd2:    seg = 7'b1101101;
      4'd3:    seg = 7'b1111001;
      4'd4:    seg = 7'b0110011;
      4'd5:    seg = 7'b1011011;
      4'd6:    seg = 7'b1011111;
      4'd7:    seg = 7'b1110000;
      4'd8:    seg = 7'b1111111;
      4'd9:    seg = 7'b1111011;
      default: seg = 7'b0000000; // non-decimal code blanks the digit
    endcase
  end
endmodule

// File: rtl/swatch_ctrl.sv
module swatch_ctrl
  import swatch_pkg::*;
(
  input  logic              clk,
  input  logic              rstAsync,
  input  logic              startIn,
  input  logic              stopIn,
  input  logic              cssIn,
  input  logic              aLtB,
  output swCtrl_t           strobes,
  output logic [NUM_ST-1:0] stateVec
);
  logic [NUM_ST-1:0] nxt;

  always_comb begin
    nxt[ST_INIT]  = 1'b0;
    nxt[ST_IDLE]  = stateVec[ST_INIT]
                  | (stateVec[ST_IDLE] & ~startIn)
                  | (stateVec[ST_HALT] & ~cssIn & startIn)
                  | (stateVec[ST_BEST] & startIn);
    nxt[ST_RUN]   = (stateVec[ST_IDLE] & startIn)
                  | (stateVec[ST_RUN] & ~stopIn);
    nxt[ST_HALT]  = (stateVec[ST_RUN] & stopIn)
                  | (stateVec[ST_HALT] & ~cssIn & ~startIn);
    nxt[ST_CMP]   = stateVec[ST_HALT] & cssIn;
    nxt[ST_STORE] = stateVec[ST_CMP] & aLtB;
    nxt[ST_BEST]  = (stateVec[ST_CMP] & ~aLtB)
                  | stateVec[ST_STORE]
                  | (stateVec[ST_BEST] & ~startIn);
  end

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) stateVec <= NUM_ST'(1) << ST_INIT;
    else          stateVec <= nxt;
  end

  always_comb begin
    strobes.ldBest   = stateVec[ST_INIT] | stateVec[ST_STORE];
    strobes.clrTimer = stateVec[ST_IDLE];
    strobes.cntEn    = stateVec[ST_RUN];
    strobes.srcTimer = stateVec[ST_STORE];
    strobes.showBest = stateVec[ST_BEST];
  end
endmodule

// File: rtl/swatch_dp.sv
module swatch_dp
  import swatch_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int FRAC_DIGITS = 2
) (
  input  logic                     clk,
  input  logic                     rstAsync,
  input  swCtrl_t                  strobes,
  output logic                     aLtB,
  output logic [DIGITS*DIGIT_W-1:0] timerVal,
  output logic [DIGITS*DIGIT_W-1:0] bestVal,
  output logic [DIGITS*SEG_W:0]    segOut
);
  localparam int WORD_W = DIGITS * DIGIT_W;
  localparam logic [WORD_W-1:0] MAX_CODE = {DIGITS{4'h9}};
  localparam int DP_POS = FRAC_DIGITS * SEG_W;

  logic [WORD_W-1:0] timerInc;
  logic [DIGITS:0]   carry;
  logic [WORD_W-1:0] dispWord;
  logic [SEG_W-1:0]  segDig [DIGITS];

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_bcdInc
    logic [DIGIT_W-1:0] dig;
    assign dig = timerVal[i*DIGIT_W +: DIGIT_W];
    always_comb begin
      if (carry[i] && dig == 4'd9) begin
        timerInc[i*DIGIT_W +: DIGIT_W] = 4'd0;
        carry[i+1] = 1'b1;
      end else begin
        timerInc[i*DIGIT_W +: DIGIT_W] = dig + {3'b000, carry[i]};
        carry[i+1] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync)                                  timerVal <= '0;
    else if (strobes.clrTimer)                     timerVal <= '0;
    else if (strobes.cntEn && timerVal != MAX_CODE) timerVal <= timerInc;
  end

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync)            bestVal <= MAX_CODE;
    else if (strobes.ldBest) bestVal <= strobes.srcTimer ? timerVal : MAX_CODE;
  end

  // packed BCD orders like an unsigned binary word
  assign aLtB     = timerVal < bestVal;
  assign dispWord = strobes.showBest ? bestVal : timerVal;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    swatch_seg7 u_seg (.bcd(dispWord[i*DIGIT_W +: DIGIT_W]), .seg(segDig[i]));
    if (i < FRAC_DIGITS) begin : g_frac
      assign segOut[i*SEG_W +: SEG_W] = segDig[i];
    end else begin : g_int
      assign segOut[i*SEG_W + 1 +: SEG_W] = segDig[i];
    end
  end
  assign segOut[DP_POS] = 1'b1;
endmodule

// File: rtl/dash_timer_top.sv
module dash_timer_top
  import swatch_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int FRAC_DIGITS = 2
) (
  input  logic                  clk,
  input  logic                  clearAll,
  input  logic                  startBtn,
  input  logic                  stopBtn,
  input  logic                  cssBtn,
  output logic [DIGITS*SEG_W:0] segOut
);
  localparam int WORD_W = DIGITS * DIGIT_W;

  swCtrl_t           strobes;
  logic [NUM_ST-1:0] stateVec;
  logic              aLtB;
  logic [WORD_W-1:0] timerVal;
  logic [WORD_W-1:0] bestVal;

  swatch_ctrl u_ctrl (
    .clk(clk), .rstAsync(clearAll), .startIn(startBtn), .stopIn(stopBtn),
    .cssIn(cssBtn), .aLtB(aLtB), .strobes(strobes), .stateVec(stateVec)
  );

  swatch_dp #(.DIGITS(DIGITS), .FRAC_DIGITS(FRAC_DIGITS)) u_dp (
    .clk(clk), .rstAsync(clearAll), .strobes(strobes), .aLtB(aLtB),
    .timerVal(timerVal), .bestVal(bestVal), .segOut(segOut)
  );
endmodule

// File: rtl/swatch_chk.sv
module swatch_chk
  import swatch_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int FRAC_DIGITS = 2
) (
  input logic                         clk,
  input logic                         rst,
  input swCtrl_t                      strobes,
  input logic [NUM_ST-1:0]            stateVec,
  input logic [DIGITS*DIGIT_W-1:0]    timerVal,
  input logic [DIGITS*DIGIT_W-1:0]    bestVal,
  input logic [DIGITS*SEG_W:0]        segOut
);
  localparam logic [DIGITS*DIGIT_W-1:0] MAX_CODE = {DIGITS{4'h9}};

  a_r2_one_state: assert property (@(posedge clk) disable iff (rst)
    $countones(stateVec) == 1);

  a_r11_timer_hold: assert property (@(posedge clk) disable iff (rst)
    !(strobes.cntEn || strobes.clrTimer) |=> $stable(timerVal));

  a_r3_count_moves: assert property (@(posedge clk) disable iff (rst)
    (strobes.cntEn && timerVal != MAX_CODE) |=> timerVal != $past(timerVal));

  a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
    (strobes.cntEn && timerVal == MAX_CODE) |=> timerVal == MAX_CODE);

  a_r6_best_hold: assert property (@(posedge clk) disable iff (rst)
    !strobes.ldBest |=> $stable(bestVal));

  a_r5_store_smaller: assert property (@(posedge clk) disable iff (rst)
    stateVec[ST_STORE] |-> timerVal < bestVal);

  a_r10_point_lit: assert property (@(posedge clk) disable iff (rst)
    segOut[FRAC_DIGITS*SEG_W] == 1'b1);
endmodule

bind dash_timer_top swatch_chk #(.DIGITS(DIGITS), .FRAC_DIGITS(FRAC_DIGITS)) u_chk (
  .clk(clk), .rst(clearAll), .strobes(strobes), .stateVec(stateVec),
  .timerVal(timerVal), .bestVal(bestVal), .segOut(segOut)
);

// File: tb/dash_timer_top_tb_top.sv
module dash_timer_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        clearAll = 1'b1;
  logic        startBtn = 1'b0;
  logic        stopBtn = 1'b0;
  logic        cssBtn = 1'b0;
  logic [28:0] segOut;
  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  dash_timer_top dut_i (
    .clk(clk), .clearAll(clearAll), .startBtn(startBtn),
    .stopBtn(stopBtn), .cssBtn(cssBtn), .segOut(segOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL R3 watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // R10 digit encoding, written from the requirement
  function automatic logic [6:0] segFor(input logic [3:0] d);
    case (d)
      4'd0: return 7'h7E; 4'd1: return 7'h30; 4'd2: return 7'h6D;
      4'd3: return 7'h79; 4'd4: return 7'h33; 4'd5: return 7'h5B;
      4'd6: return 7'h5F; 4'd7: return 7'h70; 4'd8: return 7'h7F;
      4'd9: return 7'h7B; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [28:0] dispFor(input logic [15:0] b);
    return {segFor(b[15:12]), segFor(b[11:8]), 1'b1, segFor(b[7:4]), segFor(b[3:0])};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkDisp(input logic [15:0] expBcd, input string tag);
    vectors++;
    if (segOut !== dispFor(expBcd)) begin
      miscompares++;
      $display("FAIL %s: segOut=%h expected %h", tag, segOut, dispFor(expBcd));
    end
  endtask

  // from idle: one start clock, run n clocks in total including the stop clock
  task automatic dash(input int n);
    startBtn = 1'b1; tick(1); startBtn = 1'b0;
    tick(n - 1);
    stopBtn = 1'b1; tick(1); stopBtn = 1'b0;
  endtask

  // from halted or show-best: back to idle and let the timer clear
  task automatic goIdle;
    startBtn = 1'b1; tick(1); startBtn = 1'b0; tick(1);
  endtask

  task automatic cssPulse;
    cssBtn = 1'b1; tick(1); cssBtn = 1'b0; tick(2);
  endtask

  task automatic testReset;
    tick(2);
    checkDisp(16'h0000, "R1 display during clear");
    vectors++;
    if (segOut[14] !== 1'b1) begin
      miscompares++;
      $display("FAIL R10 decimal point: got %b expected 1", segOut[14]);
    end
    clearAll = 1'b0; tick(1);
    tick(3);
    checkDisp(16'h0000, "R2 idle after clear shows zero");
  endtask

  task automatic testFirstRun;
    dash(1234);
    checkDisp(16'h1234, "R3 run of 1234 counts");
    tick(5);
    checkDisp(16'h1234, "R11 halted timer holds");
    cssPulse;
    checkDisp(16'h1234, "R5 first run beats initial 99.99 (R2)");
  endtask

  task automatic testBetterRun;
    goIdle;
    checkDisp(16'h0000, "R7 start from best view clears timer");
    dash(109);
    checkDisp(16'h0109, "R3 BCD carry at 109");
    cssPulse;
    checkDisp(16'h0109, "R5 smaller run stored");
  endtask

  task automatic testWorseAndTie;
    goIdle;
    dash(500);
    checkDisp(16'h0500, "R3 run of 500");
    cssPulse;
    checkDisp(16'h0109, "R6 slower run ignored");
    goIdle;
    dash(109);
    cssPulse;
    checkDisp(16'h0109, "R6 tie keeps best");
  endtask

  task automatic testPriority;
    goIdle;
    dash(1000);
    checkDisp(16'h1000, "R3 carry into thousands");
    cssBtn = 1'b1; startBtn = 1'b1; tick(1);
    cssBtn = 1'b0; startBtn = 1'b0; tick(2);
    checkDisp(16'h0109, "R8 compare wins over start");
  endtask

  task automatic testSaturate;
    goIdle;
    dash(10050);
    checkDisp(16'h9999, "R4 saturates at 99.99");
    tick(4);
    checkDisp(16'h9999, "R4 saturated value held");
    goIdle;
    checkDisp(16'h0000, "R7 start from halted clears timer");
  endtask

  task automatic testSessionClear;
    clearAll = 1'b1; tick(1);
    checkDisp(16'h0000, "R1 mid-session clear");
    clearAll = 1'b0; tick(1);
    dash(5000);
    checkDisp(16'h5000, "R3 run of 5000");
    cssPulse;
    checkDisp(16'h5000, "R9 best restored to 99.99 by clear");
  endtask

  initial begin
    testReset;
    testFirstRun;
    testBetterRun;
    testWorseAndTie;
    testPriority;
    testSaturate;
    testSessionClear;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule